// File: doc/BRIEF.md
# Registered Address Buffer with Parity

This block is a single register stage for memory command and address bits. A 28-bit word is captured on the rising clock edge and driven out as two identical registered copies. The two chip-select inputs are also registered and driven out. When the gating strap is high and both chip-selects are inactive (high), the data copies hold their previous values, which saves output switching.

The controller sends one parity bit with each word. The block stores that bit with the word and checks for odd parity over the stored word and the bit. The result appears one clock later on an active-low error flag. An asynchronous active-low reset clears every register and drives all data outputs low. During reset the error flag is held at its inactive high level.

Top module: `reg_addr_buf`

## Requirements
- R1: On a rising clock edge with no gating, q_a_o takes the value data_i had at that edge.
- R2: q_a_o and q_b_o always carry the same value.
- R3: While rst_ni is low, q_a_o, q_b_o and cs_q_o are low. This takes effect at once, without waiting for a clock edge.
- R4: While rst_ni is low, par_err_no is high. Reset overrides chip-select gating.
- R5: When cs_gate_en_i is 1 and both cs0_n_i and cs1_n_i are 1 at a rising edge, q_a_o and q_b_o keep their previous value.
- R6: When cs_gate_en_i is 0, the data outputs update on every edge whatever the chip-selects are. cs_q_o[0] and cs_q_o[1] always take cs0_n_i and cs1_n_i at each edge.
- R7: Parity is odd. At the edge after a word is captured, par_err_no becomes 0 if the captured data bits plus par_i contain an even number of ones, and 1 otherwise.
- R8: An edge that is held by gating captures nothing. At the following edge, par_err_no keeps its value.
- R9: After rst_ni is released, the first rising edge captures new data. par_err_no stays high until a captured word fails the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 28 | Command/address word |
| par_i | input | 1 | Odd-parity bit for data_i |
| cs0_n_i | input | 1 | Chip-select 0, active low |
| cs1_n_i | input | 1 | Chip-select 1, active low |
| cs_gate_en_i | input | 1 | Strap: 1 enables chip-select gating |
| q_a_o | output | 28 | Registered word, copy A |
| q_b_o | output | 28 | Registered word, copy B |
| cs_q_o | output | 2 | Registered chip-selects {cs1, cs0} |
| par_err_no | output | 1 | Parity error flag, active low |

## Verification
The bench runs a series of gated edges after a bad word. A design that re-evaluated parity on held cycles would release or corrupt the error flag there. It also runs edges with both chip-selects high while the strap is low, which a design that ignored the strap would freeze. Reset is asserted away from a clock edge while the flag is low, to catch a synchronous reset or a flag that is cleared to the wrong level. The bench checks that the flag lags its word by exactly one cycle, so that a design checking combinationally against the live inputs would be off by a cycle. All-ones and all-zeros words test the parity at its extremes.

// File: rtl/rab_pkg.sv
package rab_pkg;
  localparam int unsigned DATA_W     = 28;
  localparam int unsigned NUM_COPIES = 2;
  localparam int unsigned NUM_CS     = 2;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rab_capture.sv
module rab_capture #(
  parameter int unsigned W    = rab_pkg::DATA_W,
  parameter int unsigned NCS  = rab_pkg::NUM_CS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   data_i,
  input  logic           par_i,
  input  logic [NCS-1:0] cs_n_i,
  input  logic           gate_en_i,
  output logic [W-1:0]   word_o,
  output logic           par_o,
  output logic [NCS-1:0] cs_q_o,
  output logic           upd_o
);
  logic hold;
  // all selects inactive and gating strapped on
  assign hold = gate_en_i & (&cs_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      par_o  <= 1'b0;
      cs_q_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      cs_q_o <= cs_n_i;
      upd_o  <= ~hold;
      if (!hold) begin
        word_o <= data_i;
        par_o  <= par_i;
      end
    end
  end

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_en_i && (&cs_n_i)) |=> word_o == $past(data_i));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && (&cs_n_i)) |=> $stable(word_o));
  a_r6_cs_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cs_q_o == $past(cs_n_i));
  a_r3_rst_low: assert property (@(posedge clk_i)
    !rst_ni |-> (word_o == '0 && cs_q_o == '0));
endmodule

// File: rtl/rab_parity.sv
module rab_parity #(
  parameter int unsigned W = rab_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         par_i,
  input  logic         upd_i,
  output logic         err_no
);
  logic odd_ok;
  assign odd_ok = ^{word_i, par_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_no <= 1'b1;
    else if (upd_i) err_no <= odd_ok;
  end

  a_r8_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(err_no));
  a_r7_flag_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> err_no == $past(^{word_i, par_i}));
  a_r4_rst_high: assert property (@(posedge clk_i) !rst_ni |-> err_no);
endmodule

// File: rtl/rab_fanout.sv
module rab_fanout #(
  parameter int unsigned W = rab_pkg::DATA_W,
  parameter int unsigned N = rab_pkg::NUM_COPIES
) (
  input  logic [W-1:0]        word_i,
  output logic [N-1:0][W-1:0] copies_o
);
  for (genvar i = 0; i < N; i++) begin : g_copy
    assign copies_o[i] = word_i;
  end
endmodule

// File: rtl/reg_addr_buf.sv
module reg_addr_buf
  import rab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              cs0_n_i,
  input  logic              cs1_n_i,
  input  logic              cs_gate_en_i,
  output logic [DATA_W-1:0] q_a_o,
  output logic [DATA_W-1:0] q_b_o,
  output logic [1:0]        cs_q_o,
  output logic              par_err_no
);
  word_t                            word_q;
  logic                             par_q;
  logic                             upd_q;
  logic [NUM_COPIES-1:0][DATA_W-1:0] copies;

  rab_capture #(.W(DATA_W), .NCS(NUM_CS)) u_cap (
    .clk_i, .rst_ni, .data_i, .par_i,
    .cs_n_i   ({cs1_n_i, cs0_n_i}),
    .gate_en_i(cs_gate_en_i),
    .word_o   (word_q),
    .par_o    (par_q),
    .cs_q_o   (cs_q_o),
    .upd_o    (upd_q)
  );

  rab_parity #(.W(DATA_W)) u_par (
    .clk_i, .rst_ni,
    .word_i(word_q),
    .par_i (par_q),
    .upd_i (upd_q),
    .err_no(par_err_no)
  );

  rab_fanout #(.W(DATA_W), .N(NUM_COPIES)) u_fan (
    .word_i  (word_q),
    .copies_o(copies)
  );

  assign q_a_o = copies[0];
  assign q_b_o = copies[1];

  a_r2_copies_equal: assert property (@(posedge clk_i) q_a_o == q_b_o);
endmodule

// File: tb/tb_reg_addr_buf.sv
module tb_reg_addr_buf;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  // {data, par, cs1_n, cs0_n, gate_en, exp_q, exp_err}
  typedef struct packed {
    logic [27:0] data;
    logic        par;
    logic        cs1;
    logic        cs0;
    logic        en;
    logic [27:0] exp_q;
    logic        exp_err;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{28'h0000001, 1'b0, 1'b0, 1'b0, 1'b1, 28'h0000001, 1'b1}, // R1 good
    '{28'h0000003, 1'b0, 1'b1, 1'b0, 1'b1, 28'h0000003, 1'b1}, // R7 bad word
    '{28'hAAAAAAA, 1'b0, 1'b1, 1'b1, 1'b1, 28'h0000003, 1'b0}, // R5 gated, flag from prev
    '{28'h5555555, 1'b0, 1'b1, 1'b1, 1'b1, 28'h0000003, 1'b0}, // R8 flag held
    '{28'h5555555, 1'b1, 1'b1, 1'b1, 1'b0, 28'h5555555, 1'b0}, // R6 strap off
    '{28'hFFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 28'hFFFFFFF, 1'b1}, // R7 all ones bad
    '{28'h0000000, 1'b1, 1'b0, 1'b0, 1'b1, 28'h0000000, 1'b0}, // R7 zero good
    '{28'h8000000, 1'b0, 1'b1, 1'b1, 1'b0, 28'h8000000, 1'b1}, // R6 strap off
    '{28'h1234567, 1'b0, 1'b1, 1'b1, 1'b1, 28'h8000000, 1'b1}  // R5 gated
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [27:0] data = '0;
  logic        par = 1'b0, cs0 = 1'b1, cs1 = 1'b1, en = 1'b1;
  logic [27:0] q_a, q_b;
  logic [1:0]  cs_q;
  logic        err_n;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_addr_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .par_i(par),
    .cs0_n_i(cs0), .cs1_n_i(cs1), .cs_gate_en_i(en),
    .q_a_o(q_a), .q_b_o(q_b), .cs_q_o(cs_q), .par_err_no(err_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [27:0] d, input logic p, input logic c1,
                       input logic c0, input logic e);
    @(negedge clk);
    data = d; par = p; cs1 = c1; cs0 = c0; en = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R3 reset q_a", {4'h0, q_a}, 32'h0);
    chk("R3 reset q_b", {4'h0, q_b}, 32'h0);
    chk("R3 reset cs_q", {30'h0, cs_q}, 32'h0);
    chk("R4 reset flag", {31'h0, err_n}, 32'h1);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].data, VECS[i].par, VECS[i].cs1, VECS[i].cs0, VECS[i].en);
      chk("R1/R5/R6 q_a", {4'h0, q_a}, {4'h0, VECS[i].exp_q});
      chk("R2 q_b", {4'h0, q_b}, {4'h0, VECS[i].exp_q});
      chk("R6 cs_q", {30'h0, cs_q}, {30'h0, VECS[i].cs1, VECS[i].cs0});
      chk("R7/R8 flag", {31'h0, err_n}, {31'h0, VECS[i].exp_err});
    end

    // bad word ungated, then gated edge: flag low, then async reset mid-cycle
    drive(28'h0000003, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(28'h0000007, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7 flag low after bad", {31'h0, err_n}, 32'h0);
    #2 rst_n = 1'b0;
    #1;
    chk("R3 async q_a", {4'h0, q_a}, 32'h0);
    chk("R3 async cs_q", {30'h0, cs_q}, 32'h0);
    chk("R4 async flag", {31'h0, err_n}, 32'h1);
    // reset overrides gating: gated-strap selects during reset
    @(posedge clk); #1;
    chk("R4 reset vs gating", {31'h0, err_n}, 32'h1);
    chk("R3 reset vs gating", {4'h0, q_b}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R9: first edge after release captures; flag high until a bad word is evaluated
    drive(28'h0F0F0F0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 first capture", {4'h0, q_a}, 32'h00F0F0F0);
    chk("R9 flag high", {31'h0, err_n}, 32'h1);
    drive(28'h0000000, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 flag after bad eval", {31'h0, err_n}, 32'h0);
    chk("R5 held", {4'h0, q_a}, 32'h00F0F0F0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule